// File: doc/BRIEF.md
# Serial Configuration Word Loader

This block receives configuration over a three-line serial port made up of a bit clock, a data line and a frame-enable line. Each rising edge of the serial bit clock moves the data level into a 24-bit shift register, most significant bit first. A rising edge of the frame-enable line ends the frame. The two top bits of the register then choose one of four 22-bit configuration words, and the lower 22 bits are written into that word. The other three words are left as they were.

After reset, and until a word is written for the first time, each word shows a default value. The default is set by a 2-bit channel strap. Every word is also split into named control fields for the synthesizer, receiver and transmitter logic that use them. The three serial lines are sampled by the block's own clock through synchronizers, so the serial port works whatever the operating mode is. A one-cycle load strobe marks every accepted write.

Top module: `cfg_serial_regs`

## Requirements
- R1: Until a word is first written after reset, it shows its default for strap code `chan_sel` (00, 01, 10, 11). The reference divider is 16, 16, 30 or 18. The receive feedback divider is 1919, 947, 3794 or 766. The transmit feedback divider is 1943, 971, 3839 or 793. The remaining defaults are:
  - word 0: data_invert 0, mod_fsk 1, cp_cur_hi 0, lock_mode 0, pa_auto_off 0, tx_power 11, mix_gain_hi 1, lna_gain_hi 1, op_mode 00.
  - word 1: bits 21:16 zero, osc_cur_max 111, osc_cur_min 000.
  - word 2: lna_int_ctrl 0, pfd_pol_pos 1, vco_cur 01, band_low = `chan_sel[0]`.
  - word 3: mod_internal 0, lock_min_cnt 01, lock_err_win 01.
- R2: Bits shift in MSB first. On a frame end, bits 23:22 of the shift register select the target word (00 selects word_a, 01 word_b, 10 word_c, 11 word_d), and bits 21:0 are written into that word.
- R3: When a frame has more than 24 bit clocks, only the last 24 bits are used and the earlier bits have no effect.
- R4: A frame end that comes after fewer than 24 bit clocks since the previous frame end (or since reset) writes no word and raises no load strobe.
- R5: A write changes only the addressed word. Words change only on an accepted write.
- R6: word_b bits 17 and 16 always read 0, whatever value is written to them.
- R7: An accepted write updates the word three clock edges after the frame-enable line is seen high. load_strobe is high for exactly that one following cycle, and at no other time.
- R8: Field positions:
  - word_a: rx_ref_div[9:0], op_mode[11:10], lna_gain_hi[12], mix_gain_hi[13], tx_power[15:14], pa_auto_off[16], lock_mode[17], cp_cur_hi[18], mod_fsk[19], data_invert[20].
  - word_b: tx_ref_div[9:0], osc_cur_min[12:10], osc_cur_max[15:13], lna_hyst_en[18], pll_delay_off[19].
  - word_c: rx_fb_div[16:0], band_low[17], vco_cur[19:18], pfd_pol_pos[20], lna_int_ctrl[21].
  - word_d: tx_fb_div[16:0], lock_err_win[18:17], lock_min_cnt[20:19], mod_internal[21].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_sel | input | 2 | Channel strap selecting the default words |
| ser_clk | input | 1 | Serial bit clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_en | input | 1 | Frame enable; rising edge ends a frame |
| word_a | output | 22 | Word 0 (address 00) |
| word_b | output | 22 | Word 1 (address 01) |
| word_c | output | 22 | Word 2 (address 10) |
| word_d | output | 22 | Word 3 (address 11) |
| load_strobe | output | 1 | One-cycle pulse per accepted write |
| rx_ref_div | output | 10 | Receive reference divider |
| op_mode | output | 2 | Operating mode field |
| lna_gain_hi | output | 1 | High LNA gain |
| mix_gain_hi | output | 1 | High mixer gain |
| tx_power | output | 2 | Transmit power step |
| pa_auto_off | output | 1 | Disable PA turn-on after lock |
| lock_mode | output | 1 | Lock-detect analysis mode |
| cp_cur_hi | output | 1 | High charge-pump current |
| mod_fsk | output | 1 | FSK (1) or ASK (0) modulation |
| data_invert | output | 1 | Invert transmit data |
| tx_ref_div | output | 10 | Transmit reference divider |
| osc_cur_min | output | 3 | Oscillator minimum current code |
| osc_cur_max | output | 3 | Oscillator maximum current code |
| lna_hyst_en | output | 1 | LNA hysteresis enable |
| pll_delay_off | output | 1 | Delayed PLL start control |
| rx_fb_div | output | 17 | Receive feedback divider |
| band_low | output | 1 | Lower band select |
| vco_cur | output | 2 | VCO current code |
| pfd_pol_pos | output | 1 | Phase detector polarity |
| lna_int_ctrl | output | 1 | Internal LNA gain control |
| tx_fb_div | output | 17 | Transmit feedback divider |
| lock_err_win | output | 2 | Lock error window code |
| lock_min_cnt | output | 2 | Lock minimum count code |
| mod_internal | output | 1 | Internal modulation control |

## Verification
The bench sends frames longer than 24 bits. A design that kept the first bits instead of the last would land the payload in the wrong word. It ends frames early, after a partial frame, and also completes a frame whose bits straddle an idle gap. A design without a bit counter, or one that never cleared it at a frame end, would write stale data or miss valid frames. All ones are written to word_b to catch test bits that leak through. Resets under every strap code check the defaults. A word that came up with a wrong or mixed value would differ from the model from the first cycle.

// File: rtl/cfg_regs_pkg.sv
package cfg_regs_pkg;
  localparam int FRAME_W   = 24;
  localparam int ADDR_W    = 2;
  localparam int DATA_W    = FRAME_W - ADDR_W;
  localparam int NUM_WORDS = 1 << ADDR_W;
  localparam int CNT_W     = $clog2(FRAME_W + 1);

  typedef logic [DATA_W-1:0] cfg_word_t;

  // word 1 keeps its two test bits cleared
  localparam int        TEST_WORD_IDX = 1;
  localparam cfg_word_t TEST_KEEP     = ~(cfg_word_t'(3) << 16);

  function automatic cfg_word_t default_word(input logic [1:0] chan,
                                             input logic [1:0] idx);
    logic [9:0]  ref_div;
    logic [16:0] fb_rx;
    logic [16:0] fb_tx;
    cfg_word_t   w;
    case (chan)
      2'b00:   begin ref_div = 10'd16; fb_rx = 17'd1919; fb_tx = 17'd1943; end
      2'b01:   begin ref_div = 10'd16; fb_rx = 17'd947;  fb_tx = 17'd971;  end
      2'b10:   begin ref_div = 10'd30; fb_rx = 17'd3794; fb_tx = 17'd3839; end
      default: begin ref_div = 10'd18; fb_rx = 17'd766;  fb_tx = 17'd793;  end
    endcase
    case (idx)
      2'd0:    w = {1'b0, 1'b0, 1'b1, 3'b000, 2'b11, 1'b1, 1'b1, 2'b00, ref_div};
      2'd1:    w = {4'b0000, 2'b00, 3'b111, 3'b000, ref_div};
      2'd2:    w = {1'b0, 1'b1, 2'b01, chan[0], fb_rx};
      default: w = {1'b0, 2'b01, 2'b01, fb_tx};
    endcase
    return w;
  endfunction
endpackage

// File: rtl/cfg_line_sync.sv
module cfg_line_sync #(
  parameter int               LINES     = 3,
  parameter int               STAGES    = 2,
  parameter logic [LINES-1:0] EDGE_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d_in,
  output logic [LINES-1:0] d_out
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    if (EDGE_MASK[g]) begin : g_edge
      localparam int DEPTH = STAGES + 1;
      logic [DEPTH-1:0] pipe_q;
      logic [DEPTH-1:0] pipe_d;
      always_comb pipe_d = {pipe_q[DEPTH-2:0], d_in[g]};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
      end
      assign d_out[g] = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    end else begin : g_level
      logic [STAGES-1:0] pipe_q;
      logic [STAGES-1:0] pipe_d;
      if (STAGES > 1) begin : g_multi
        always_comb pipe_d = {pipe_q[STAGES-2:0], d_in[g]};
      end else begin : g_single
        always_comb pipe_d = d_in[g];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
      end
      assign d_out[g] = pipe_q[STAGES-1];
    end
  end
endmodule

// File: rtl/cfg_shift_capture.sv
module cfg_shift_capture
  import cfg_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic              frame_end,
  output logic              commit,
  output logic [ADDR_W-1:0] addr,
  output cfg_word_t         payload
);
  logic [FRAME_W-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               cnt_full;

  assign cnt_full = (cnt_q == CNT_W'(FRAME_W));

  always_comb begin
    shift_d = shift_q;
    if (shift_en) shift_d = {shift_q[FRAME_W-2:0], bit_in};
  end

  always_comb begin
    cnt_d = cnt_q;
    if (frame_end)                 cnt_d = '0;
    else if (shift_en && !cnt_full) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
    end
  end

  assign commit  = frame_end && cnt_full;
  assign addr    = shift_q[FRAME_W-1 -: ADDR_W];
  assign payload = shift_q[DATA_W-1:0];
endmodule

// File: rtl/cfg_word_bank.sv
module cfg_word_bank
  import cfg_regs_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [1:0]                       chan,
  input  logic                             commit,
  input  logic [ADDR_W-1:0]                addr,
  input  cfg_word_t                        payload,
  output logic [NUM_WORDS-1:0]             wr_en,
  output logic [NUM_WORDS-1:0][DATA_W-1:0] words,
  output logic                             load_strobe
);
  logic strobe_q;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    cfg_word_t data_q, data_d, keep;
    logic      valid_q, valid_d;

    if (g == TEST_WORD_IDX) begin : g_masked
      assign keep = TEST_KEEP;
    end else begin : g_plain
      assign keep = '1;
    end

    assign wr_en[g] = commit && (addr == ADDR_W'(g));

    always_comb begin
      data_d  = data_q;
      valid_d = valid_q;
      if (wr_en[g]) begin
        data_d  = payload & keep;
        valid_d = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en[g]) data_q <= data_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= valid_d;
    end

    assign words[g] = valid_q ? data_q : default_word(chan, ADDR_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= commit;
  end

  assign load_strobe = strobe_q;
endmodule

// File: rtl/cfg_serial_regs.sv
module cfg_serial_regs
  import cfg_regs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  chan_sel,
  input  logic        ser_clk,
  input  logic        ser_data,
  input  logic        ser_en,
  output logic [21:0] word_a,
  output logic [21:0] word_b,
  output logic [21:0] word_c,
  output logic [21:0] word_d,
  output logic        load_strobe,
  output logic [9:0]  rx_ref_div,
  output logic [1:0]  op_mode,
  output logic        lna_gain_hi,
  output logic        mix_gain_hi,
  output logic [1:0]  tx_power,
  output logic        pa_auto_off,
  output logic        lock_mode,
  output logic        cp_cur_hi,
  output logic        mod_fsk,
  output logic        data_invert,
  output logic [9:0]  tx_ref_div,
  output logic [2:0]  osc_cur_min,
  output logic [2:0]  osc_cur_max,
  output logic        lna_hyst_en,
  output logic        pll_delay_off,
  output logic [16:0] rx_fb_div,
  output logic        band_low,
  output logic [1:0]  vco_cur,
  output logic        pfd_pol_pos,
  output logic        lna_int_ctrl,
  output logic [16:0] tx_fb_div,
  output logic [1:0]  lock_err_win,
  output logic [1:0]  lock_min_cnt,
  output logic        mod_internal
);
  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // line 0 data level, line 1 bit-clock rise, line 2 frame-enable rise
  logic [2:0] sync_out;
  cfg_line_sync #(
    .LINES     (3),
    .STAGES    (SYNC_STAGES),
    .EDGE_MASK (3'b110)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_in  ({ser_en, ser_clk, ser_data}),
    .d_out (sync_out)
  );

  logic              commit;
  logic [ADDR_W-1:0] addr;
  cfg_word_t         payload;
  cfg_shift_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .shift_en  (sync_out[1]),
    .bit_in    (sync_out[0]),
    .frame_end (sync_out[2]),
    .commit    (commit),
    .addr      (addr),
    .payload   (payload)
  );

  logic [NUM_WORDS-1:0]             wr_en;
  logic [NUM_WORDS-1:0][DATA_W-1:0] words;
  cfg_word_bank u_bank (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .chan        (chan_sel),
    .commit      (commit),
    .addr        (addr),
    .payload     (payload),
    .wr_en       (wr_en),
    .words       (words),
    .load_strobe (load_strobe)
  );

  assign word_a = words[0];
  assign word_b = words[1];
  assign word_c = words[2];
  assign word_d = words[3];

  assign rx_ref_div    = word_a[9:0];
  assign op_mode       = word_a[11:10];
  assign lna_gain_hi   = word_a[12];
  assign mix_gain_hi   = word_a[13];
  assign tx_power      = word_a[15:14];
  assign pa_auto_off   = word_a[16];
  assign lock_mode     = word_a[17];
  assign cp_cur_hi     = word_a[18];
  assign mod_fsk       = word_a[19];
  assign data_invert   = word_a[20];

  assign tx_ref_div    = word_b[9:0];
  assign osc_cur_min   = word_b[12:10];
  assign osc_cur_max   = word_b[15:13];
  assign lna_hyst_en   = word_b[18];
  assign pll_delay_off = word_b[19];

  assign rx_fb_div     = word_c[16:0];
  assign band_low      = word_c[17];
  assign vco_cur       = word_c[19:18];
  assign pfd_pol_pos   = word_c[20];
  assign lna_int_ctrl  = word_c[21];

  assign tx_fb_div     = word_d[16:0];
  assign lock_err_win  = word_d[18:17];
  assign lock_min_cnt  = word_d[20:19];
  assign mod_internal  = word_d[21];
endmodule

// File: rtl/cfg_serial_regs_chk.sv
module cfg_serial_regs_chk #(
  parameter int NUM_WORDS = 4,
  parameter int DATA_W    = 22
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 commit,
  input logic [NUM_WORDS-1:0] wr_en,
  input logic                 load_strobe,
  input logic [DATA_W-1:0]    word_a,
  input logic [DATA_W-1:0]    word_b,
  input logic [DATA_W-1:0]    word_c,
  input logic [DATA_W-1:0]    word_d
);
  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |=> !load_strobe);

  // R7
  strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> load_strobe);

  // R2
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($countones(wr_en) == 1));

  // R2
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  // R5
  words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable({word_a, word_b, word_c, word_d}));

  // R6
  test_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_b[17:16] == 2'b00);
endmodule

bind cfg_serial_regs cfg_serial_regs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .commit      (commit),
  .wr_en       (wr_en),
  .load_strobe (load_strobe),
  .word_a      (word_a),
  .word_b      (word_b),
  .word_c      (word_c),
  .word_d      (word_d)
);

// File: tb/tb_cfg_serial_regs.sv
module tb_cfg_serial_regs;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [1:0]  chan_sel = 2'b00;
  logic        ser_clk = 1'b0, ser_data = 1'b0, ser_en = 1'b0;
  logic [21:0] word_a, word_b, word_c, word_d;
  logic        load_strobe;
  logic [9:0]  rx_ref_div, tx_ref_div;
  logic [1:0]  op_mode, tx_power, vco_cur, lock_err_win, lock_min_cnt;
  logic        lna_gain_hi, mix_gain_hi, pa_auto_off, lock_mode, cp_cur_hi;
  logic        mod_fsk, data_invert, lna_hyst_en, pll_delay_off, band_low;
  logic        pfd_pol_pos, lna_int_ctrl, mod_internal;
  logic [2:0]  osc_cur_min, osc_cur_max;
  logic [16:0] rx_fb_div, tx_fb_div;

  cfg_serial_regs dut (.*);

  int n_chk = 0, n_fail = 0;
  logic        running = 1'b0;
  logic [21:0] exp_w [4];
  logic        exp_strobe = 1'b0;
  logic [23:0] shadow = '0;
  int          edges = 0;

  function automatic logic [21:0] dflt(input logic [1:0] ch, input int idx);
    int rd, nr, nt;
    case (ch)
      2'b00:   begin rd = 16; nr = 1919; nt = 1943; end
      2'b01:   begin rd = 16; nr = 947;  nt = 971;  end
      2'b10:   begin rd = 30; nr = 3794; nt = 3839; end
      default: begin rd = 18; nr = 766;  nt = 793;  end
    endcase
    case (idx)
      0:       return {1'b0, 1'b0, 1'b1, 3'b000, 2'b11, 1'b1, 1'b1, 2'b00, 10'(rd)};
      1:       return {4'b0000, 2'b00, 3'b111, 3'b000, 10'(rd)};
      2:       return {1'b0, 1'b1, 2'b01, ch[0], 17'(nr)};
      default: return {1'b0, 2'b01, 2'b01, 17'(nt)};
    endcase
  endfunction

  task automatic check(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (running) begin
      check(word_a == exp_w[0], "R5 word_a", 64'(word_a), 64'(exp_w[0]));
      check(word_b == exp_w[1], "R5 word_b", 64'(word_b), 64'(exp_w[1]));
      check(word_c == exp_w[2], "R5 word_c", 64'(word_c), 64'(exp_w[2]));
      check(word_d == exp_w[3], "R5 word_d", 64'(word_d), 64'(exp_w[3]));
      check(load_strobe == exp_strobe, "R7 load_strobe",
            64'(load_strobe), 64'(exp_strobe));
      check(word_b[17:16] == 2'b00, "R6 test bits", 64'(word_b[17:16]), 64'(0));
      check({data_invert, mod_fsk, cp_cur_hi, lock_mode, pa_auto_off, tx_power,
             mix_gain_hi, lna_gain_hi, op_mode, rx_ref_div} == exp_w[0][20:0],
            "R8 word_a fields",
            64'({data_invert, mod_fsk, cp_cur_hi, lock_mode, pa_auto_off, tx_power,
                 mix_gain_hi, lna_gain_hi, op_mode, rx_ref_div}), 64'(exp_w[0][20:0]));
      check({pll_delay_off, lna_hyst_en, osc_cur_max, osc_cur_min, tx_ref_div}
              == {exp_w[1][19:18], exp_w[1][15:0]}, "R8 word_b fields",
            64'({pll_delay_off, lna_hyst_en, osc_cur_max, osc_cur_min, tx_ref_div}),
            64'({exp_w[1][19:18], exp_w[1][15:0]}));
      check({lna_int_ctrl, pfd_pol_pos, vco_cur, band_low, rx_fb_div} == exp_w[2],
            "R8 word_c fields",
            64'({lna_int_ctrl, pfd_pol_pos, vco_cur, band_low, rx_fb_div}), 64'(exp_w[2]));
      check({mod_internal, lock_min_cnt, lock_err_win, tx_fb_div} == exp_w[3],
            "R8 word_d fields",
            64'({mod_internal, lock_min_cnt, lock_err_win, tx_fb_div}), 64'(exp_w[3]));
    end
  end

  task automatic do_reset(input logic [1:0] ch);
    @(negedge clk);
    rst_n    = 1'b0;
    chan_sel = ch;
    for (int i = 0; i < 4; i++) exp_w[i] = dflt(ch, i);
    shadow = '0;
    edges  = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 explicit default checks
    check(word_a == dflt(ch, 0), "R1 default word_a", 64'(word_a), 64'(dflt(ch, 0)));
    check(word_b == dflt(ch, 1), "R1 default word_b", 64'(word_b), 64'(dflt(ch, 1)));
    check(word_c == dflt(ch, 2), "R1 default word_c", 64'(word_c), 64'(dflt(ch, 2)));
    check(word_d == dflt(ch, 3), "R1 default word_d", 64'(word_d), 64'(dflt(ch, 3)));
  endtask

  task automatic send_bits(input logic [63:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      ser_data = bits[i];
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      shadow  = {shadow[22:0], bits[i]};
      edges++;
      repeat (3) @(negedge clk);
      ser_clk = 1'b0;
    end
  endtask

  task automatic end_frame();
    logic [21:0] pl;
    int          idx;
    @(negedge clk);
    ser_en = 1'b1;
    repeat (3) @(posedge clk);
    if (edges >= 24) begin
      idx = int'(shadow[23:22]);
      pl  = shadow[21:0];
      if (idx == 1) pl[17:16] = 2'b00;
      exp_w[idx] = pl;
      exp_strobe = 1'b1;
    end
    edges = 0;
    @(posedge clk);
    exp_strobe = 1'b0;
    repeat (3) @(negedge clk);
    ser_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 4; i++) exp_w[i] = dflt(2'b00, i);
    running = 1'b1;
    do_reset(2'b00);

    // R2: one frame per address
    send_bits(64'({2'b00, 22'h15A5C3}), 24); end_frame();
    check(word_a == 22'h15A5C3, "R2 word_a write", 64'(word_a), 64'(22'h15A5C3));
    send_bits(64'({2'b01, 22'h3FFFFF}), 24); end_frame();
    // R6: all-ones write leaves test bits clear
    check(word_b == 22'h3CFFFF, "R6 word_b write", 64'(word_b), 64'(22'h3CFFFF));
    send_bits(64'({2'b10, 22'h2AAAAA}), 24); end_frame();
    check(word_c == 22'h2AAAAA, "R2 word_c write", 64'(word_c), 64'(22'h2AAAAA));
    send_bits(64'({2'b11, 22'h155555}), 24); end_frame();
    check(word_d == 22'h155555, "R2 word_d write", 64'(word_d), 64'(22'h155555));

    // R3: 30-bit frame, six leading bits discarded
    send_bits(64'({6'b110111, 2'b01, 22'h0A1234}), 30); end_frame();
    check(word_b == 22'h081234, "R3 long frame", 64'(word_b), 64'(22'h081234));
    check(word_d == 22'h155555, "R3 other word kept", 64'(word_d), 64'(22'h155555));

    // R4: short frame ignored
    send_bits(64'({2'b00, 18'h3C0F0}), 20); end_frame();
    check(word_a == 22'h15A5C3, "R4 short frame", 64'(word_a), 64'(22'h15A5C3));
    // R4: full frame then a short one right after
    send_bits(64'({2'b10, 22'h012345}), 24); end_frame();
    send_bits(64'h3FF, 10); end_frame();
    check(word_c == 22'h012345, "R4 short after full", 64'(word_c), 64'(22'h012345));

    // R3: frame split by an idle gap still counts as 24 bits
    send_bits(64'({2'b00, 8'hA5}), 10);
    repeat (20) @(negedge clk);
    send_bits(64'(14'h1E3C), 14); end_frame();
    check(word_a == {8'hA5, 14'h1E3C}, "R3 split frame",
          64'(word_a), 64'({8'hA5, 14'h1E3C}));

    // R1: defaults under the other straps
    do_reset(2'b10);
    send_bits(64'({2'b11, 22'h3ABCDE}), 24); end_frame();
    do_reset(2'b11);
    do_reset(2'b01);
    send_bits(64'({2'b00, 22'h0F0F0F}), 24); end_frame();

    repeat (10) @(negedge clk);
    running = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule